// File: doc/BRIEF.md
# Stochastic Resistive-Cell Logic Gate

This block models one bipolar resistive memory cell that is used as a stateful logic element. The cell stores a single bit. Low resistance stands for 1 and high resistance for 0. On every operating cycle the block applies a level to each of the cell's two terminals. A drive with terminal one high and terminal two low pushes the cell toward 1. The opposite drive pushes it toward 0. Equal levels leave the cell alone. A push that would change the bit succeeds only with a run-time probability. A pseudo-random draw is compared against an 8-bit threshold to decide each such push.

A small sequencer runs a gate recipe, chosen by a 4-bit code. Every recipe begins with one initialization cycle, which always succeeds. Zero, one or two logic cycles follow, and each logic cycle drives the terminals from fixed levels or from the operands p and q. When the recipe ends, the bit left in the cell is the gate output. Lowering the probability trades accuracy for weaker drives: at full probability every gate is exact, and below it the outputs become statistically wrong at rates set by the recipe.

Top module: `sgate_top`

## Requirements
- R1: After reset, busy_o, done_o and result_o are all 0.
- R2: A logic cycle that drives (terminal one, terminal two) = (1,0) can only leave the cell at 1, (0,1) can only leave it at 0, and equal levels never change it.
- R3: The initialization cycle always writes the recipe's initial value, whatever the probability. FALSE, NIMP, CNIMP, PASS_P, NOT_P, PASS_Q and NOT_Q start at 0. The others start at 1.
- R4: With prob_i = 255, the result equals the gate selected by gate_i: 0 FALSE, 1 TRUE, 2 AND, 3 NAND, 4 OR, 5 NOR, 6 IMP (~p|q), 7 CIMP (p|~q), 8 NIMP (p&~q), 9 CNIMP (~p&q), 10 PASS_P, 11 NOT_P, 12 PASS_Q, 13 NOT_Q.
- R5: A start with gate_i 14 or 15, the two functions one cell cannot form, is ignored: busy_o and done_o stay 0 and result_o keeps its value.
- R6: An accepted start raises busy_o on the next cycle. busy_o stays high for one cycle plus one cycle per logic step: 1 for FALSE and TRUE, 2 for IMP, CIMP, NIMP, CNIMP, PASS and NOT, 3 for AND, NAND, OR and NOR. done_o pulses for exactly one cycle as busy_o falls, with result_o already valid.
- R7: While busy_o is high, start_i is ignored, and changes on p_i, q_i, gate_i and prob_i do not affect the running gate.
- R8: A logic cycle that would change the cell succeeds when an 8-bit draw from a 16-bit maximal-length LFSR is below prob_i. prob_i = 255 always succeeds and prob_i = 0 never does. A cycle that would not change the cell takes no draw.
- R9: NAND at prob_i = 128 gives s = 0.5. Inputs (0,0) and (1,0) always produce 1, and the average accuracy over uniform inputs is close to (3 + s*s)/4 = 0.8125.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to run a gate; taken only when idle with a valid code |
| gate_i | input | 4 | Gate code |
| p_i | input | 1 | First operand |
| q_i | input | 1 | Second operand |
| prob_i | input | 8 | Switching probability threshold |
| busy_o | output | 1 | Recipe in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 1 | Bit stored in the cell |

## Verification
The assertions assume that the sequencer is the only source of terminal drives. They also assume the probability threshold is fixed for the whole run, because it is latched at start. The direction and hold checks therefore relate the drives to the cell bit on the next cycle. The stimulus changes inputs only between clock edges and holds start_i for a single cycle. Operands, codes and thresholds come from a seeded random source, and deliberate changes during busy probe the latching. Exact truth tables are checked at full probability. The statistical checks use tolerance bands that are wide enough for the fixed seed.

// File: rtl/sgate_pkg.sv
package sgate_pkg;
  localparam int GATE_W  = 4;
  localparam int N_GATES = 14;

  typedef enum logic [1:0] {SRC_ZERO, SRC_ONE, SRC_P, SRC_Q} src_e;

  typedef struct packed {
    logic       init_val;
    logic [1:0] n_steps;
    src_e       a1, b1;   // step 1: terminal one, terminal two
    src_e       a2, b2;   // step 2
  } recipe_t;

  function automatic logic gate_ok(input logic [GATE_W-1:0] code);
    return int'(code) < N_GATES;
  endfunction

  function automatic logic pick(input src_e s, input logic p, input logic q);
    case (s)
      SRC_ZERO: return 1'b0;
      SRC_ONE:  return 1'b1;
      SRC_P:    return p;
      default:  return q;
    endcase
  endfunction

  function automatic recipe_t recipe_of(input logic [GATE_W-1:0] code);
    recipe_t r;
    r = '{init_val: 1'b0, n_steps: 2'd0, a1: SRC_ZERO, b1: SRC_ZERO, a2: SRC_ZERO, b2: SRC_ZERO};
    case (code)
      4'd1:  r.init_val = 1'b1;
      4'd2:  r = '{1'b1, 2'd2, SRC_P,    SRC_ONE,  SRC_Q,   SRC_ONE};
      4'd3:  r = '{1'b1, 2'd2, SRC_ZERO, SRC_Q,    SRC_ONE, SRC_P};
      4'd4:  r = '{1'b1, 2'd2, SRC_Q,    SRC_ONE,  SRC_P,   SRC_ZERO};
      4'd5:  r = '{1'b1, 2'd2, SRC_ZERO, SRC_P,    SRC_ZERO, SRC_Q};
      4'd6:  r = '{1'b1, 2'd1, SRC_Q,    SRC_P,    SRC_ZERO, SRC_ZERO};
      4'd7:  r = '{1'b1, 2'd1, SRC_P,    SRC_Q,    SRC_ZERO, SRC_ZERO};
      4'd8:  r = '{1'b0, 2'd1, SRC_P,    SRC_Q,    SRC_ZERO, SRC_ZERO};
      4'd9:  r = '{1'b0, 2'd1, SRC_Q,    SRC_P,    SRC_ZERO, SRC_ZERO};
      4'd10: r = '{1'b0, 2'd1, SRC_P,    SRC_ZERO, SRC_ZERO, SRC_ZERO};
      4'd11: r = '{1'b0, 2'd1, SRC_ONE,  SRC_P,    SRC_ZERO, SRC_ZERO};
      4'd12: r = '{1'b0, 2'd1, SRC_Q,    SRC_ZERO, SRC_ZERO, SRC_ZERO};
      4'd13: r = '{1'b0, 2'd1, SRC_ONE,  SRC_Q,    SRC_ZERO, SRC_ZERO};
      default: ;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sgate_lfsr.sv
module sgate_lfsr #(
  parameter int          LFSR_W = 16,
  parameter int          OUT_W  = 8,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [OUT_W-1:0] rnd_o
);
  logic [LFSR_W-1:0] lfsr_q;
  logic              fb;

  assign fb    = ^(lfsr_q & TAPS);
  assign rnd_o = lfsr_q[OUT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lfsr_q <= SEED;
    else if (adv_i) lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
  end

  p_lfsr_nonzero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);
  p_lfsr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(lfsr_q));
endmodule

// File: rtl/sgate_cell.sv
module sgate_cell #(
  parameter int PROB_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              force_i,
  input  logic              init_i,
  input  logic              apply_i,
  input  logic              t1_i,
  input  logic              t2_i,
  input  logic [PROB_W-1:0] prob_i,
  input  logic [PROB_W-1:0] rnd_i,
  output logic              draw_o,
  output logic              state_o
);
  localparam logic [PROB_W-1:0] PROB_FULL = '1;

  logic state_q, qualify, success;

  // a draw is spent only when the drive would actually change the bit
  assign qualify = apply_i && (t1_i != t2_i) && (state_q != t1_i);
  assign success = (prob_i == PROB_FULL) || (rnd_i < prob_i);
  assign draw_o  = qualify;
  assign state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  state_q <= 1'b0;
    else if (force_i)             state_q <= init_i;
    else if (qualify && success)  state_q <= t1_i;
  end

  p_same_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_i && (t1_i == t2_i) |=> $stable(state_q));
  p_set_dir_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_i && t1_i && !t2_i && state_q |=> state_q);
  p_reset_dir_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_i && !t1_i && t2_i && !state_q |=> !state_q);
  p_full_prob_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_i && (t1_i != t2_i) && (prob_i == PROB_FULL) |=> state_q == $past(t1_i));
  p_zero_prob_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_i && (prob_i == '0) |=> $stable(state_q));
  p_force_init_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> state_q == $past(init_i));
  p_excl_drive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(force_i && apply_i));
endmodule

// File: rtl/sgate_seq.sv
module sgate_seq
  import sgate_pkg::*;
#(
  parameter int PROB_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [GATE_W-1:0] gate_i,
  input  logic              p_i,
  input  logic              q_i,
  input  logic [PROB_W-1:0] prob_i,
  output logic              force_o,
  output logic              init_o,
  output logic              apply_o,
  output logic              t1_o,
  output logic              t2_o,
  output logic [PROB_W-1:0] prob_o,
  output logic              busy_o,
  output logic              done_o
);
  logic              busy_q, done_q, p_q, q_q;
  logic [1:0]        idx_q;
  logic [GATE_W-1:0] code_q;
  logic [PROB_W-1:0] prob_q;
  recipe_t           rcp;
  logic              last, accept;

  assign rcp    = recipe_of(code_q);
  assign last   = (idx_q == rcp.n_steps);
  assign accept = start_i && !busy_q && gate_ok(gate_i);

  assign force_o = busy_q && (idx_q == 2'd0);
  assign apply_o = busy_q && (idx_q != 2'd0);
  assign init_o  = rcp.init_val;
  assign t1_o    = (idx_q == 2'd1) ? pick(rcp.a1, p_q, q_q) : pick(rcp.a2, p_q, q_q);
  assign t2_o    = (idx_q == 2'd1) ? pick(rcp.b1, p_q, q_q) : pick(rcp.b2, p_q, q_q);
  assign prob_o  = prob_q;
  assign busy_o  = busy_q;
  assign done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      code_q <= '0;
      p_q    <= 1'b0;
      q_q    <= 1'b0;
      prob_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        code_q <= gate_i;
        p_q    <= p_i;
        q_q    <= q_i;
        prob_q <= prob_i;
      end else if (busy_q) begin
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 2'd1;
        end
      end
    end
  end

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_done_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
  p_args_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) |-> $stable(code_q) && $stable(prob_q) && $stable(p_q) && $stable(q_q));
  p_bad_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> gate_ok(code_q));
endmodule

// File: rtl/sgate_top.sv
module sgate_top
  import sgate_pkg::*;
#(
  parameter int                PROB_W = 8,
  parameter int                LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAPS   = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED   = 16'hACE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [GATE_W-1:0] gate_i,
  input  logic              p_i,
  input  logic              q_i,
  input  logic [PROB_W-1:0] prob_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              result_o
);
  logic              force_en, init_val, apply_en, t1, t2, draw;
  logic [PROB_W-1:0] prob_run, rnd;

  sgate_seq #(.PROB_W(PROB_W)) u_seq (
    .clk_i, .rst_ni, .start_i, .gate_i, .p_i, .q_i, .prob_i,
    .force_o(force_en), .init_o(init_val), .apply_o(apply_en),
    .t1_o(t1), .t2_o(t2), .prob_o(prob_run), .busy_o, .done_o
  );

  sgate_lfsr #(.LFSR_W(LFSR_W), .OUT_W(PROB_W), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
    .clk_i, .rst_ni, .adv_i(draw), .rnd_o(rnd)
  );

  sgate_cell #(.PROB_W(PROB_W)) u_cell (
    .clk_i, .rst_ni, .force_i(force_en), .init_i(init_val), .apply_i(apply_en),
    .t1_i(t1), .t2_i(t2), .prob_i(prob_run), .rnd_i(rnd),
    .draw_o(draw), .state_o(result_o)
  );
endmodule

// File: tb/tb_sgate_top.sv
module tb_sgate_top;
  logic       clk = 1'b0, rst_ni = 1'b0, start = 1'b0, p = 1'b0, q = 1'b0;
  logic [3:0] gate = '0;
  logic [7:0] prob = '0;
  logic       busy, done, result;

  int n_chk = 0, n_bad = 0, cyc = 0;

  sgate_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .gate_i(gate), .p_i(p), .q_i(q),
    .prob_i(prob), .busy_o(busy), .done_o(done), .result_o(result)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic ref_gate(input int c, input logic a, input logic b);
    case (c)
      0: return 1'b0;       1: return 1'b1;
      2: return a & b;      3: return ~(a & b);
      4: return a | b;      5: return ~(a | b);
      6: return ~a | b;     7: return a | ~b;
      8: return a & ~b;     9: return ~a & b;
      10: return a;         11: return ~a;
      12: return b;         default: return ~b;
    endcase
  endfunction

  function automatic int ref_busy(input int c);
    if (c <= 1) return 1;
    if (c <= 5) return 3;
    return 2;
  endfunction

  function automatic logic ref_init(input int c);
    return (c <= 7) && (c != 0);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // drive at negedge, sample at negedge
  task automatic run_gate(input int c, input logic a, input logic b, input logic [7:0] pr,
                          output logic res, output int nbusy);
    int guard;
    @(negedge clk);
    gate = 4'(c); p = a; q = b; prob = pr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nbusy = 0; guard = 0;
    while (!done && guard < 20) begin
      if (busy) nbusy++;
      @(negedge clk);
      guard++;
    end
    res = result;
    if (!done) begin n_chk++; n_bad++; $display("FAIL R6 actual=no_done expected=done"); end
  endtask

  initial begin
    logic r;
    int nb, seed, hits, tot;
    seed = $urandom(32'd1357);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 result", result, 0);
    rst_ni = 1'b1;

    // R4/R6 full truth tables at P=255
    for (int c = 0; c < 14; c++)
      for (int v = 0; v < 4; v++) begin
        run_gate(c, v[1], v[0], 8'hFF, r, nb);
        check($sformatf("R4 gate%0d p%0d q%0d", c, v[1], v[0]), r, ref_gate(c, v[1], v[0]));
        check($sformatf("R6 busy gate%0d", c), nb, ref_busy(c));
      end

    // R6 done lasts one cycle
    @(negedge clk);
    check("R6 done pulse", done, 0);

    // R3 init deterministic at P=0
    run_gate(11, 1'b1, 1'b0, 8'hFF, r, nb);
    check("R3 prep NOT_P", r, 0);
    run_gate(2, 1'b1, 1'b1, 8'h00, r, nb);
    check("R3 AND init at P0", r, 1);
    run_gate(11, 1'b1, 1'b0, 8'h00, r, nb);
    check("R3 NOT_P init at P0", r, 0);
    for (int c = 0; c < 14; c++) begin
      run_gate(c, 1'b0, 1'b0, 8'h00, r, nb);
      // P=0: no logic step can move the cell, result is init value (R3, R8)
      check($sformatf("R3 gate%0d init P0", c), r, ref_init(c));
    end

    // R8 P=0 never switches, R2 equal levels hold
    run_gate(3, 1'b1, 1'b1, 8'h00, r, nb);
    check("R8 NAND(1,1) P0", r, 1);
    run_gate(11, 1'b0, 1'b0, 8'h00, r, nb);
    check("R8 NOT_P(0) P0", r, 0);
    run_gate(3, 1'b1, 1'b0, 8'h80, r, nb);
    check("R2 NAND(1,0) equal levels hold", r, 1);

    // R5 rejected codes
    run_gate(11, 1'b0, 1'b0, 8'hFF, r, nb);
    for (int c = 14; c < 16; c++) begin
      hits = 0;
      @(negedge clk);
      gate = 4'(c); prob = 8'hFF; p = 1'b0; q = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 6; k++) begin
        if (busy || done) hits++;
        @(negedge clk);
      end
      check($sformatf("R5 code%0d no activity", c), hits, 0);
      check($sformatf("R5 code%0d result held", c), result, 1);
    end

    // R7 inputs latched, start ignored while busy
    @(negedge clk);
    gate = 4'd3; p = 1'b1; q = 1'b1; prob = 8'hFF; start = 1'b1;
    @(negedge clk);
    gate = 4'd1; p = 1'b0; q = 1'b0; prob = 8'h00;
    nb = 0;
    for (int k = 0; k < 8 && !done; k++) begin
      if (busy) nb++;
      @(negedge clk);
      start = 1'b0;
    end
    check("R7 NAND held result", result, 0);
    check("R7 busy length", nb, 3);
    @(negedge clk);
    check("R7 no restart", busy, 0);

    // random exact checks at P=255
    for (int i = 0; i < 300; i++) begin
      int c;
      logic a, b;
      c = int'($urandom % 14); a = 1'($urandom); b = 1'($urandom);
      run_gate(c, a, b, 8'hFF, r, nb);
      check($sformatf("R4 rand gate%0d", c), r, ref_gate(c, a, b));
    end

    // R9 NAND statistics at P=128
    hits = 0; tot = 0;
    for (int i = 0; i < 2000; i++) begin
      logic a, b;
      a = 1'($urandom); b = 1'($urandom);
      run_gate(3, a, b, 8'd128, r, nb);
      if (r == ~(a & b)) hits++;
      tot++;
      if (!b) check("R9 NAND deterministic pattern", r, 1);
    end
    $display("NAND accuracy at P=128: %0d / %0d", hits, tot);
    check("R9 accuracy low bound", int'(hits * 1000 >= tot * 770), 1);
    check("R9 accuracy high bound", int'(hits * 1000 <= tot * 855), 1);
    finish_run();
  end

  initial begin
    wait (cyc >= 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    finish_run();
  end
endmodule